// File: doc/BRIEF.md
# Multiply-Aware Issue Interlock

This block sits at the issue point of a scalar pipeline whose execute stage has two paths. One is a single-cycle ALU. The other is a separate pipelined multiplier that takes four execute stages. Both paths then share the memory and writeback stages. The block keeps a short shift register of the multiplies now inside the multiplier, with the destination register of each. From that record it decides, every cycle, whether the instruction waiting in decode may move into execute.

Two hazards hold an instruction back. The first is ordering. A single-cycle instruction issued right behind a multiply would reach writeback first. That breaks in-order completion: a same-register write could be lost, and an exception on the younger instruction would see imprecise state. The second is a read-after-write dependence on a multiply result that is not yet produced.

Decode offers an instruction with `dec_valid`. The offer is accepted at the next rising edge when `iss_grant` is high. When `iss_stall` is high, decode must hold the same instruction and keep offering it. The block sends a bubble down the pipeline in its place. Grant and stall are combinational functions of the offer and the tracked state. The interlock never holds back decode in any other way.

Top module: `mul_issue_ilk`

## Requirements
- R1: After reset no multiply is tracked, so the first valid instruction is granted in the same cycle. This holds even if multiplies were offered while reset was active.
- R2: `iss_grant` and `iss_stall` are never high together, and both are low whenever `dec_valid` is low. A valid offer raises exactly one of them.
- R3: A granted multiply with a nonzero destination is tracked from the next cycle for exactly four cycles (EX1 to EX4), moving one stage per cycle, and is then dropped.
- R4: A non-multiply instruction stalls while any tracked multiply is in EX1, EX2 or EX3. If a multiply is granted in cycle c, a non-multiply offered in cycles c+1 to c+3 stalls and is granted in cycle c+4. Its writeback then falls strictly after the multiply's.
- R5: Multiplies with no dependence are granted back to back, one per cycle.
- R6: A multiply stalls while either enabled source equals the destination of a tracked multiply in EX1 to EX3. A dependence on a multiply in EX4 does not stall. A dependent multiply offered right after its producer (granted in cycle c) is granted in cycle c+4.
- R7: Register 0 never causes a dependence. A multiply writing register 0 is not tracked, and a source naming register 0 never matches.
- R8: A source whose enable (`dec_src_a_en` / `dec_src_b_en`) is low is ignored for dependence checks.
- R9: A stalled instruction is not tracked. The slot it would have taken holds a bubble.
- R10: An offer with `dec_valid` low is never tracked, even when `dec_is_mul` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; clears all tracking |
| dec_valid | input | 1 | Decode offers an instruction |
| dec_is_mul | input | 1 | Offered instruction uses the multiplier |
| dec_dst | input | 5 | Destination register (0 = no write) |
| dec_src_a | input | 5 | First source register |
| dec_src_a_en | input | 1 | First source is read |
| dec_src_b | input | 5 | Second source register |
| dec_src_b_en | input | 1 | Second source is read |
| iss_grant | output | 1 | Offer moves to execute at the next edge |
| iss_stall | output | 1 | Offer must be held; a bubble is issued |

## Verification
The bench offers a non-multiply in each of the three cycles after a multiply, and again in the fourth. An off-by-one in the ordering window would either grant too early, so that completion goes out of order, or stall one cycle too long. Dependent multiplies are tested against a producer in EX1 to EX3 and in EX4, on each source port separately. A design that compared the wrong range of stages would grant into a stale value or lose a cycle. The bench also probes the cases that must leave no trace. These are a stalled multiply, an invalid offer carrying the multiply flag, a multiply writing register 0, and a source with its enable low. If any of them were tracked, a non-multiply offered a few cycles later would stall when it should be granted.

// File: rtl/mul_ilk_pkg.sv
package mul_ilk_pkg;
  parameter int unsigned ILK_REG_W = 5;

  typedef logic [ILK_REG_W-1:0] reg_idx_t;

  typedef struct packed {
    logic     vld;
    reg_idx_t dst;
  } mul_slot_t;

  typedef enum logic [1:0] {
    HZ_NONE  = 2'd0,
    HZ_ORDER = 2'd1,
    HZ_RAW   = 2'd2
  } hz_cause_e;
endpackage

// File: rtl/mul_ilk_track.sv
module mul_ilk_track
  import mul_ilk_pkg::*;
#(
  parameter int unsigned MUL_STAGES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        push,
  input  reg_idx_t                    push_dst,
  output mul_slot_t [MUL_STAGES-1:0]  slots
);
  mul_slot_t [MUL_STAGES-1:0] slots_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slots_q <= '0;
    end else begin
      slots_q[0].vld <= push;
      slots_q[0].dst <= push ? push_dst : '0;
      for (int k = 1; k < MUL_STAGES; k++) begin
        slots_q[k] <= slots_q[k-1];
      end
    end
  end

  assign slots = slots_q;
endmodule

// File: rtl/mul_ilk_hazard.sv
module mul_ilk_hazard
  import mul_ilk_pkg::*;
#(
  parameter int unsigned MUL_STAGES = 4,
  parameter int unsigned ALU_STAGES = 1
) (
  input  mul_slot_t [MUL_STAGES-1:0] slots,
  input  logic                       is_mul,
  input  reg_idx_t                   src_a,
  input  logic                       src_a_en,
  input  reg_idx_t                   src_b,
  input  logic                       src_b_en,
  output logic                       order_block,
  output logic                       raw_block
);
  // A slot blocks a short instruction while that instruction's writeback
  // would not land strictly after the multiply's.
  localparam int unsigned ORDER_LIM = MUL_STAGES - ALU_STAGES;
  // A result becomes available for forwarding at the end of the last stage.
  localparam int unsigned RAW_LIM   = MUL_STAGES - 1;

  logic [MUL_STAGES-1:0] order_hit;
  logic [MUL_STAGES-1:0] raw_hit;
  logic                  a_live;
  logic                  b_live;

  assign a_live = src_a_en && (src_a != '0);
  assign b_live = src_b_en && (src_b != '0);

  for (genvar k = 0; k < MUL_STAGES; k++) begin : g_slot
    if (k < ORDER_LIM) begin : g_ord
      assign order_hit[k] = slots[k].vld;
    end else begin : g_no_ord
      assign order_hit[k] = 1'b0;
    end
    if (k < RAW_LIM) begin : g_raw
      assign raw_hit[k] = slots[k].vld &&
                          ((a_live && (src_a == slots[k].dst)) ||
                           (b_live && (src_b == slots[k].dst)));
    end else begin : g_no_raw
      assign raw_hit[k] = 1'b0;
    end
  end

  assign order_block = !is_mul && (|order_hit);
  assign raw_block   = |raw_hit;
endmodule

// File: rtl/mul_issue_ilk.sv
module mul_issue_ilk
  import mul_ilk_pkg::*;
#(
  parameter int unsigned MUL_STAGES = 4,
  parameter int unsigned ALU_STAGES = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dec_valid,
  input  logic                 dec_is_mul,
  input  logic [ILK_REG_W-1:0] dec_dst,
  input  logic [ILK_REG_W-1:0] dec_src_a,
  input  logic                 dec_src_a_en,
  input  logic [ILK_REG_W-1:0] dec_src_b,
  input  logic                 dec_src_b_en,
  output logic                 iss_grant,
  output logic                 iss_stall
);
  mul_slot_t [MUL_STAGES-1:0] slots;
  logic                       order_block;
  logic                       raw_block;
  logic                       push;
  hz_cause_e                  cause;

  mul_ilk_track #(.MUL_STAGES(MUL_STAGES)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_dst (dec_dst),
    .slots    (slots)
  );

  mul_ilk_hazard #(.MUL_STAGES(MUL_STAGES), .ALU_STAGES(ALU_STAGES)) u_hazard (
    .slots       (slots),
    .is_mul      (dec_is_mul),
    .src_a       (dec_src_a),
    .src_a_en    (dec_src_a_en),
    .src_b       (dec_src_b),
    .src_b_en    (dec_src_b_en),
    .order_block (order_block),
    .raw_block   (raw_block)
  );

  always_comb begin
    cause = HZ_NONE;
    if (raw_block)        cause = HZ_RAW;
    else if (order_block) cause = HZ_ORDER;
  end

  assign iss_grant = dec_valid && (cause == HZ_NONE);
  assign iss_stall = dec_valid && (cause != HZ_NONE);
  // Writes to register 0 change no state, so they need no tracking.
  assign push      = iss_grant && dec_is_mul && (dec_dst != '0);
endmodule

// File: rtl/mul_ilk_chk.sv
module mul_ilk_chk
  import mul_ilk_pkg::*;
#(
  parameter int unsigned MUL_STAGES = 4,
  parameter int unsigned ALU_STAGES = 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 dec_valid,
  input logic                 dec_is_mul,
  input logic [ILK_REG_W-1:0] dec_dst,
  input logic [ILK_REG_W-1:0] dec_src_a,
  input logic                 dec_src_a_en,
  input logic [ILK_REG_W-1:0] dec_src_b,
  input logic                 dec_src_b_en,
  input logic                 iss_grant,
  input logic                 iss_stall
);
  localparam int unsigned AGE_MAX = MUL_STAGES + 1;
  localparam int unsigned AGE_W   = $clog2(AGE_MAX + 1);
  localparam int unsigned AGE_OK  = MUL_STAGES - ALU_STAGES + 1;

  logic [AGE_W-1:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n)                                          age <= AGE_W'(AGE_MAX);
    else if (iss_grant && dec_is_mul && dec_dst != '0)   age <= AGE_W'(1);
    else if (age != AGE_W'(AGE_MAX))                     age <= age + AGE_W'(1);
  end

  AST_GRANT_STALL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(iss_grant && iss_stall)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> (!iss_grant && !iss_stall)); // R2
  AST_ALU_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_grant && !dec_is_mul) |-> (age >= AGE_W'(AGE_OK))); // R4
  AST_RAW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(iss_grant && dec_is_mul && dec_dst != '0) &&
     dec_valid && dec_src_a_en && dec_src_a == $past(dec_dst)) |-> !iss_grant); // R6
  AST_MUL_NOSRC_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_is_mul && !dec_src_a_en && !dec_src_b_en) |-> iss_grant); // R5
  AST_EMPTY_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && age == AGE_W'(AGE_MAX)) |-> iss_grant); // R1
endmodule

bind mul_issue_ilk mul_ilk_chk #(.MUL_STAGES(MUL_STAGES), .ALU_STAGES(ALU_STAGES)) u_chk (.*);

// File: tb/mul_issue_ilk_bench.sv
module mul_issue_ilk_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dec_valid = 1'b0;
  logic       dec_is_mul = 1'b0;
  logic [4:0] dec_dst = '0;
  logic [4:0] dec_src_a = '0;
  logic       dec_src_a_en = 1'b0;
  logic [4:0] dec_src_b = '0;
  logic       dec_src_b_en = 1'b0;
  logic       iss_grant;
  logic       iss_stall;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mul_issue_ilk u_mul_issue_ilk (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_is_mul(dec_is_mul),
    .dec_dst(dec_dst), .dec_src_a(dec_src_a), .dec_src_a_en(dec_src_a_en),
    .dec_src_b(dec_src_b), .dec_src_b_en(dec_src_b_en),
    .iss_grant(iss_grant), .iss_stall(iss_stall)
  );

  // Drive one offer at the falling edge, sample mid-low-phase, then move on.
  task automatic cyc(input bit v, input bit m, input int d, input int a, input bit ae,
                     input int b, input bit be, input bit eg, input bit es, input string tag);
    dec_valid = v; dec_is_mul = m; dec_dst = 5'(d);
    dec_src_a = 5'(a); dec_src_a_en = ae; dec_src_b = 5'(b); dec_src_b_en = be;
    #1;
    n_chk++;
    if (iss_grant !== eg || iss_stall !== es) begin
      n_bad++;
      $display("FAIL %s: grant/stall = %b/%b expected %b/%b", tag, iss_grant, iss_stall, eg, es);
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 idle quiet");
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    dec_valid = 1'b1; dec_is_mul = 1'b1; dec_dst = 5'd6;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cyc(1, 0, 7, 6, 1, 0, 0, 1, 0, "R1 first offer after reset");
    idle(2);
  endtask

  task automatic t_alu_after_mul;
    cyc(1, 1, 5, 1, 1, 2, 1, 1, 0, "R5 lone multiply");
    for (int i = 1; i <= 3; i++) cyc(1, 0, 7, 3, 1, 0, 0, 0, 1, "R4 short op behind multiply");
    cyc(1, 0, 7, 3, 1, 0, 0, 1, 0, "R4 R3 short op after multiply leaves EX3");
    idle(6);
  endtask

  task automatic t_mul_chain;
    for (int i = 0; i < 4; i++) cyc(1, 1, 20 + i, 1, 1, 2, 1, 1, 0, "R5 back-to-back multiplies");
    for (int i = 1; i <= 3; i++) cyc(1, 0, 8, 0, 0, 0, 0, 0, 1, "R3 tail multiply still tracked");
    cyc(1, 0, 8, 0, 0, 0, 0, 1, 0, "R3 last multiply dropped");
    idle(6);
  endtask

  task automatic t_raw(input bit use_b);
    cyc(1, 1, 9, 1, 1, 0, 0, 1, 0, "R6 producer multiply");
    for (int i = 1; i <= 3; i++)
      cyc(1, 1, 10, use_b ? 4 : 9, 1, use_b ? 9 : 4, 1, 0, 1, "R6 dependent multiply EX1-EX3");
    cyc(1, 1, 10, use_b ? 4 : 9, 1, use_b ? 9 : 4, 1, 1, 0, "R6 dependent multiply at EX4");
    idle(6);
  endtask

  task automatic t_src_en;
    cyc(1, 1, 11, 1, 1, 0, 0, 1, 0, "R8 producer");
    cyc(1, 1, 12, 11, 0, 11, 0, 1, 0, "R8 disabled sources ignored");
    idle(6);
  endtask

  task automatic t_reg0;
    cyc(1, 1, 0, 1, 1, 0, 0, 1, 0, "R7 multiply to r0");
    cyc(1, 0, 4, 0, 1, 0, 1, 1, 0, "R7 short op after r0 multiply");
    cyc(1, 1, 0, 1, 1, 0, 0, 1, 0, "R7 multiply to r0 again");
    cyc(1, 1, 13, 0, 1, 0, 1, 1, 0, "R7 r0 source never matches");
    idle(6);
  endtask

  task automatic t_bubble;
    cyc(1, 1, 14, 1, 1, 0, 0, 1, 0, "R9 producer");
    cyc(1, 1, 15, 14, 1, 0, 0, 0, 1, "R9 dependent stalls");
    idle(2);
    cyc(1, 0, 16, 0, 0, 0, 0, 1, 0, "R9 stalled multiply left no slot");
    idle(6);
  endtask

  task automatic t_invalid;
    cyc(0, 1, 17, 0, 0, 0, 0, 0, 0, "R10 invalid multiply offer");
    cyc(1, 0, 18, 17, 1, 0, 0, 1, 0, "R10 nothing tracked from invalid offer");
    idle(2);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_alu_after_mul();
    t_mul_chain();
    t_raw(1'b0);
    t_raw(1'b1);
    t_src_en();
    t_reg0();
    t_bubble();
    t_invalid();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run incomplete, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule